// File: doc/BRIEF.md
# Feedback Gain Loop with Clamped Float-Style Gain Word

This block closes an automatic gain control loop around a complex I/Q sample stream. Each valid sample arrives with a magnitude value from an upstream Cartesian-to-polar stage. The block subtracts that magnitude from a programmed threshold to get an error. A programmable loop gain scales the error, and an accumulator integrates the result. After each addition the accumulator is clamped between a programmed floor and a programmed ceiling.

The top eight bits of the accumulator form the gain word. Its layout, from the most significant bit down, is a 2-bit exponent and then a 6-bit fraction. The gain it stands for is (1 + m/64) · 2^e, which covers roughly 0 to 24 dB. The block multiplies the I and Q samples by this gain, saturates the products to the sample width and registers them. Software sets up the threshold, the limits and the loop gain through a small register port, and can read back the current gain word.

The magnitude input already carries the converter's processing gain of about 1.64. The threshold must therefore be programmed in those same scaled units. Clearing the loop enable freezes the gain at its present value.

Top module: `gain_loop`

## Requirements
- R1: While reset is high and right after it, gain_word is 0x00 (the reset floor), out_valid is 0, out_i and out_q are 0, and register 1 reads 0xFF00.
- R2: gain_word always presents the top 8 bits of the accumulator, and register 3 returns the same value in bits [7:0]. The accumulator has 8 + FRAC_W bits, so one gain-word LSB equals 2^FRAC_W accumulator units.
- R3: On a cycle with in_valid high and the loop enabled, the accumulator adds step = floor((thr − in_mag) · (16 + lgm) / 2^(4 + lgs)). Here thr is the threshold, lgm is the 4-bit loop mantissa and lgs is the 3-bit loop shift.
- R4: After each update the accumulator is no larger than ceiling · 2^FRAC_W. The ceiling is register 1 bits [15:8].
- R5: After each update the accumulator is no smaller than floor · 2^FRAC_W. The floor is register 1 bits [7:0].
- R6: If the floor is programmed above the ceiling, the floor wins: after an update the accumulator equals floor · 2^FRAC_W.
- R7: When the loop enable (register 2 bit 7) is 0, the accumulator and gain_word do not change on valid samples.
- R8: A valid sample x appears on out_i/out_q one cycle later as floor(x · (64 + m) · 2^e / 64). The values m and e come from the gain word held before that same sample's update.
- R9: Scaled outputs saturate to +2^(IQ_W−1)−1 or −2^(IQ_W−1) instead of wrapping.
- R10: out_valid is in_valid delayed by one cycle. The outputs hold their value on cycles that follow an idle input.
- R11: Register 0 bits [MAG_W−1:0] hold the threshold. Register 1 holds {ceiling, floor}. Register 2 holds lgm in [3:0], lgs in [6:4] and the enable in [7]. Each reads back what was written, and writes to register 3 are ignored.
- R12: Cycles with in_valid low leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | IQ_W | In-phase sample, signed |
| in_q | input | IQ_W | Quadrature sample, signed |
| in_mag | input | MAG_W | Unsigned magnitude of the sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, combinational |
| out_valid | output | 1 | Scaled sample strobe |
| out_i | output | IQ_W | Scaled in-phase sample |
| out_q | output | IQ_W | Scaled quadrature sample |
| gain_word | output | 8 | Current exponent/fraction gain word |

## Verification
On one valid edge the accumulator takes its new value and the I/Q pair is scaled, so the two actions coincide. The scaling has to use the gain word from before that update. The bench provokes this with long runs of back-to-back samples at the steepest loop setting, where the gain word changes on every sample. A reference model computes the output from the old word and the new word from the clamped sum, and it compares both on every cycle. Random runs add limit rewrites, including floor-above-ceiling settings, and idle gaps between samples.

// File: rtl/gain_loop.sv
module gain_loop #(
  parameter int IQ_W   = 16,
  parameter int MAG_W  = 12,
  parameter int FRAC_W = 12,
  parameter int LG_M_W = 4,
  parameter int LG_S_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IQ_W-1:0]  in_i,
  input  logic signed [IQ_W-1:0]  in_q,
  input  logic [MAG_W-1:0]        in_mag,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_addr,
  input  logic [15:0]             cfg_wdata,
  output logic [15:0]             cfg_rdata,
  output logic                    out_valid,
  output logic signed [IQ_W-1:0]  out_i,
  output logic signed [IQ_W-1:0]  out_q,
  output logic [7:0]              gain_word
);
  localparam int WORD_W = 8;
  localparam int ACC_W  = WORD_W + FRAC_W;
  localparam int ERR_W  = MAG_W + 1;
  localparam int LGF_W  = LG_M_W + 2;
  localparam int PRD_W  = ERR_W + LGF_W;
  localparam int SUM_W  = ACC_W + 2;
  localparam int MUL_W  = IQ_W + 8;
  localparam int SHL_W  = MUL_W + 3;
  localparam int PAD2_W = 16 - 1 - LG_S_W - LG_M_W;
  localparam logic [WORD_W-1:0] FLOOR_RST = 8'h00;
  localparam logic [WORD_W-1:0] CEIL_RST  = 8'hFF;
  localparam logic signed [SHL_W-1:0] SAT_HI =
    $signed({{(SHL_W-IQ_W+1){1'b0}}, {(IQ_W-1){1'b1}}});
  localparam logic signed [SHL_W-1:0] SAT_LO =
    $signed({{(SHL_W-IQ_W+1){1'b1}}, {(IQ_W-1){1'b0}}});

  logic [MAG_W-1:0]   thr_q;
  logic [WORD_W-1:0]  lim_lo, lim_hi;
  logic [LG_M_W-1:0]  lg_man;
  logic [LG_S_W-1:0]  lg_shf;
  logic               loop_en;
  logic [ACC_W-1:0]   acc;

  logic signed [ERR_W-1:0] err;
  logic signed [LGF_W-1:0] lg_fac;
  logic signed [PRD_W-1:0] prod, step;
  logic signed [SUM_W-1:0] sum, hi_b, lo_b, capped, acc_nxt;

  assign err    = $signed({1'b0, thr_q}) - $signed({1'b0, in_mag});
  assign lg_fac = $signed({2'b01, lg_man});
  assign prod   = err * lg_fac;
  assign step   = prod >>> (LG_M_W + lg_shf);
  assign sum    = $signed({2'b00, acc}) + SUM_W'(step);
  assign hi_b   = $signed({2'b00, lim_hi, {FRAC_W{1'b0}}});
  assign lo_b   = $signed({2'b00, lim_lo, {FRAC_W{1'b0}}});
  assign capped  = (sum > hi_b) ? hi_b : sum;
  assign acc_nxt = (capped < lo_b) ? lo_b : capped;

  assign gain_word = acc[ACC_W-1 -: WORD_W];

  function automatic logic signed [IQ_W-1:0] apply_gain(
    input logic signed [IQ_W-1:0] x,
    input logic [WORD_W-1:0]      g
  );
    logic signed [MUL_W-1:0] p;
    logic signed [SHL_W-1:0] s;
    logic signed [SHL_W-1:0] r;
    p = x * $signed({2'b01, g[5:0]});
    s = SHL_W'(p) <<< g[7:6];
    r = s >>> 6;
    if (r > SAT_HI)      r = SAT_HI;
    else if (r < SAT_LO) r = SAT_LO;
    return r[IQ_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= '0;
      lim_lo  <= FLOOR_RST;
      lim_hi  <= CEIL_RST;
      lg_man  <= '0;
      lg_shf  <= '0;
      loop_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: thr_q <= cfg_wdata[MAG_W-1:0];
        2'd1: begin
          lim_lo <= cfg_wdata[7:0];
          lim_hi <= cfg_wdata[15:8];
        end
        2'd2: begin
          lg_man  <= cfg_wdata[LG_M_W-1:0];
          lg_shf  <= cfg_wdata[LG_M_W +: LG_S_W];
          loop_en <= cfg_wdata[LG_M_W+LG_S_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       acc <= {FLOOR_RST, {FRAC_W{1'b0}}};
    else if (in_valid && loop_en)  acc <= acc_nxt[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= apply_gain(in_i, gain_word);
        out_q <= apply_gain(in_q, gain_word);
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {{(16-MAG_W){1'b0}}, thr_q};
      2'd1:    cfg_rdata = {lim_hi, lim_lo};
      2'd2:    cfg_rdata = {{PAD2_W{1'b0}}, loop_en, lg_shf, lg_man};
      default: cfg_rdata = {8'h00, gain_word};
    endcase
  end
endmodule

module gain_loop_chk #(
  parameter int IQ_W   = 16,
  parameter int FRAC_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   loop_en,
  input logic [8+FRAC_W-1:0]    acc,
  input logic [7:0]             lim_lo,
  input logic [7:0]             lim_hi,
  input logic                   out_valid,
  input logic signed [IQ_W-1:0] out_i
);
  // R4
  acc_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && loop_en && lim_lo <= lim_hi) |=> acc <= {$past(lim_hi), {FRAC_W{1'b0}}});
  // R5
  acc_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && loop_en) |=> acc >= {$past(lim_lo), {FRAC_W{1'b0}}});
  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && loop_en) |=> $stable(acc));
  // R10
  strobe_on_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  strobe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_i));
endmodule

bind gain_loop gain_loop_chk #(.IQ_W(IQ_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .loop_en(loop_en), .acc(acc),
  .lim_lo(lim_lo), .lim_hi(lim_hi), .out_valid(out_valid), .out_i(out_i)
);

// File: tb/tb_gain_loop.sv
`timescale 1ns/1ps
module tb_gain_loop;
  localparam int FR = 12;
  logic clk = 0, rst = 1;
  logic in_valid = 0;
  logic signed [15:0] in_i = 0, in_q = 0;
  logic [11:0] in_mag = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic out_valid;
  logic signed [15:0] out_i, out_q;
  logic [7:0] gain_word;
  int nchk = 0, nfail = 0;

  int m_thr = 0, m_lo = 0, m_hi = 255, m_gm = 0, m_gs = 0, m_en = 0;
  int m_acc = 0, m_oi = 0, m_oq = 0;

  always #2 clk = ~clk;

  gain_loop dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mstep(input int mag);
    int p;
    p = (m_thr - mag) * (16 + m_gm);
    return p >>> (4 + m_gs);
  endfunction

  function automatic int mclamp(input int v);
    int r;
    r = v;
    if (r > (m_hi << FR)) r = m_hi << FR;
    if (r < (m_lo << FR)) r = m_lo << FR;
    return r;
  endfunction

  function automatic int mscale(input int x, input int w);
    int p;
    p = x * (64 + (w & 63));
    p = p <<< (w >> 6);
    p = p >>> 6;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  task automatic wr(input int addr, input int data);
    cfg_we = 1; cfg_addr = addr[1:0]; cfg_wdata = data[15:0];
    @(posedge clk); #1;
    cfg_we = 0;
    case (addr)
      0: m_thr = data & 12'hFFF;
      1: begin m_lo = data & 255; m_hi = (data >> 8) & 255; end
      2: begin m_gm = data & 15; m_gs = (data >> 4) & 7; m_en = (data >> 7) & 1; end
      default: ;
    endcase
  endtask

  task automatic rd(input int addr, input int exp, input string req);
    cfg_addr = addr[1:0];
    #1;
    chk(cfg_rdata == exp[15:0], req, cfg_rdata, exp);
  endtask

  task automatic sample(input bit v, input int i, input int q, input int mag, input string req);
    in_valid = v; in_i = i[15:0]; in_q = q[15:0]; in_mag = mag[11:0];
    if (v) begin
      m_oi = mscale(i, m_acc >> FR);
      m_oq = mscale(q, m_acc >> FR);
      if (m_en != 0) m_acc = mclamp(m_acc + mstep(mag));
    end
    @(posedge clk); #1;
    in_valid = 0;
    chk(out_valid == v, req, out_valid, v);
    chk(out_i == m_oi, req, out_i, m_oi);
    chk(out_q == m_oq, req, out_q, m_oq);
    chk(gain_word == (m_acc >> FR), req, gain_word, m_acc >> FR);
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(gain_word == 0, "R1", gain_word, 0);
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(out_i == 0 && out_q == 0, "R1", out_i, 0);
    rst = 0;
    rd(1, 16'hFF00, "R1");
    rd(3, 0, "R2");

    // R11 register readback, write to read-only ignored
    wr(0, 12'h7A5); rd(0, 12'h7A5, "R11");
    wr(1, 16'h9C20); rd(1, 16'h9C20, "R11");
    wr(2, 16'h003F); rd(2, 16'h003F, "R11");
    wr(3, 16'h55AA); rd(3, 0, "R11");

    // R7 loop disabled: gain frozen, unity scaling (R8)
    for (int k = 0; k < 5; k++) sample(1, 1000 * k - 2000, 300 - 77 * k, 0, "R7");
    chk(gain_word == 0, "R7", gain_word, 0);

    // R3 R4 R8 steep climb, word changes every sample
    wr(0, 4095); wr(2, 16'h008F);
    for (int k = 0; k < 100; k++) sample(1, 1234 - 25 * k, -777 + 13 * k, 0, "R3");
    chk(gain_word == 8'h9C, "R4", gain_word, 8'h9C);
    rd(3, 8'h9C, "R2");

    // R12 R10 idle cycles hold state and outputs
    for (int k = 0; k < 4; k++) sample(0, 9999, -9999, 0, "R12");
    rd(3, 8'h9C, "R12");

    // R5 fall to floor
    wr(0, 0);
    for (int k = 0; k < 100; k++) sample(1, 500 + k, -500 - k, 4095, "R5");
    chk(gain_word == 8'h20, "R5", gain_word, 8'h20);

    // R6 floor above ceiling
    wr(1, 16'h4080);
    sample(1, 10, 10, 4095, "R6");
    chk(gain_word == 8'h80, "R6", gain_word, 8'h80);

    // R9 saturation at maximum gain
    wr(1, 16'hFFFF);
    sample(1, 0, 0, 2000, "R9");
    chk(gain_word == 8'hFF, "R9", gain_word, 8'hFF);
    sample(1, 20000, -20000, 0, "R9");
    chk(out_i == 32767, "R9", out_i, 32767);
    chk(out_q == -32768, "R9", out_q, -32768);
    sample(1, 100, -100, 0, "R8");
    chk(out_i == 1587 && out_q == -1588, "R8", out_i, 1587);

    // random mix of samples, limit and loop settings
    wr(1, 16'hE010); wr(2, 16'h0080 | 16'h0025);
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 100;
      if (r == 0) begin
        int a, b;
        a = $urandom % 256; b = $urandom % 256;
        if (($urandom % 5) != 0 && a > b) begin int t; t = a; a = b; b = t; end
        wr(1, (b << 8) | a);
      end else if (r == 1) begin
        wr(2, ($urandom % 128) | ((($urandom % 4) != 0) ? 128 : 0));
      end else if (r == 2) begin
        wr(0, $urandom % 4096);
      end else begin
        sample(($urandom % 4) != 0, $signed($urandom % 65536) - 32768,
               $signed($urandom % 65536) - 32768, $urandom % 4096, "R8");
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule